// File: doc/BRIEF.md
# Smart Card Supply Supervisor Controller

This controller decides when a smart card interface may run, based on the state of the supply monitor. It also reports card presence to a host through a single active-low status line. Two digitised comparator outputs come in. `vdd_ok` means the supply is above the upper threshold, which already includes the hysteresis. `vdd_low` means the supply is below the lower threshold. The interface stays locked in its inactive state until the supply has been above the upper threshold for a programmable number of clock cycles. While it is locked, every level on the host command line is ignored.

Once the interface is enabled, the host opens a session with a falling edge on its active-low command line `cmd_n`. The controller answers with an activation request, which is held until the contact sequencer acknowledges it. The session is closed in any of three ways: the host raises `cmd_n`, the card is removed, or the supply drops below the lower threshold. In each case the controller issues a one-cycle deactivation request and waits for the acknowledge before it returns to the inactive state. A supply drop while the interface is inactive only restarts the hold-off and issues nothing.

The status output `status_off` behaves in two ways. With `cmd_n` high it follows card presence. With `cmd_n` low it reports whether the current session was ended by a fault.

Top module: `scard_supv_ctrl`

## Requirements
- R1: After a synchronous reset the block is inactive: `if_enable`, `contacts_live`, `act_req`, `deact_req` and `status_off` are all 0.
- R2: `if_enable` rises after exactly HOLD_CYC clock edges at which `vdd_ok`=1 and `vdd_low`=0. Until then, command-line edges start no activation.
- R3: `vdd_low`=1 at any edge clears the hold-off count and drops `if_enable` at that edge. Counting starts again from zero.
- R4: In the inactive state, with `if_enable`=1, `card_in`=1 and `vdd_low`=0, a `cmd_n` falling edge (1 at one edge, 0 at the next) raises `act_req` and `contacts_live` at that edge. `act_ack` then clears `act_req` at the following edge and the session becomes active. With `card_in`=0, no activation occurs.
- R5: `vdd_low`=1 while activating or active gives a `deact_req` pulse lasting exactly one cycle. `contacts_live` stays 1 until `deact_ack` is sampled.
- R6: `vdd_low`=1 while inactive never produces `deact_req`.
- R7: `card_in`=0 while active triggers the same deactivation as R5.
- R8: `cmd_n` returning to 1 while active triggers deactivation.
- R9: With `cmd_n`=1, `status_off` equals `card_in` one cycle later (1 means a card is present, 0 means no card).
- R10: With `cmd_n`=0, `status_off` is 1 unless the session was ended by undervoltage or card removal. In that case it is 0 until `cmd_n` is sampled high.
- R11: `contacts_live` is 0 whenever the block is inactive.
- R12: If `vdd_low`=1 in the same cycle as a `cmd_n` falling edge, no activation occurs. If `vdd_low`=1 in the same cycle as `act_ack`, deactivation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_ok | input | 1 | Supply above upper threshold |
| vdd_low | input | 1 | Supply below lower threshold |
| card_in | input | 1 | Card presence switch, 1 = present |
| cmd_n | input | 1 | Host session command, active low |
| act_ack | input | 1 | Activation sequence complete |
| deact_ack | input | 1 | Deactivation sequence complete |
| if_enable | output | 1 | Hold-off elapsed, interface may run |
| act_req | output | 1 | Activation request, held until acknowledged |
| deact_req | output | 1 | One-cycle deactivation request |
| contacts_live | output | 1 | Card contacts driven (0 = grounded/inactive) |
| status_off | output | 1 | Active-low status to host |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is session start and undervoltage: the bench drives the `cmd_n` falling edge at the same edge that `vdd_low` rises, and expects neither `act_req` nor live contacts. The second pair is activation completion and undervoltage: the bench raises `act_ack` and `vdd_low` together. It expects a deactivation pulse, `act_req` cleared, and contacts that stay live until the deactivation acknowledge arrives. Hold-off restarts are swept over every interruption point below HOLD_CYC, with a command edge injected each time.

// File: rtl/scard_supv_pkg.sv
package scard_supv_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_RUN   = 2'd2,
        SEQ_STOP  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic supply_drop;
        logic card_gone;
        logic host_end;
    } abort_cause_t;

    function automatic logic cause_any(input abort_cause_t c);
        return c.supply_drop | c.card_gone | c.host_end;
    endfunction

    function automatic logic cause_fault(input abort_cause_t c);
        return c.supply_drop | c.card_gone;
    endfunction

    function automatic logic state_live(input seq_state_e s);
        return (s == SEQ_START) || (s == SEQ_RUN);
    endfunction

endpackage

// File: rtl/supv_holdoff.sv
module supv_holdoff #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic vdd_ok,
    input  logic vdd_low,
    output logic ready
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || vdd_low) begin
            cnt <= '0;
        end else if (vdd_ok && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == LIM);

    // R3
    low_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        vdd_low |=> !ready);

    // R2
    ready_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(vdd_ok) && !$past(vdd_low)));

endmodule

// File: rtl/supv_seq.sv
module supv_seq
    import scard_supv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ready,
    input  logic vdd_low,
    input  logic card_in,
    input  logic cmd_n,
    input  logic act_ack,
    input  logic deact_ack,
    output logic act_req,
    output logic deact_req,
    output logic contacts_live,
    output logic fault_evt
);
    seq_state_e   state, nxt;
    abort_cause_t why;
    logic         cmd_q, cmd_fall, live, start_ok, abort_now;

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= 1'b1;
        else     cmd_q <= cmd_n;
    end

    assign cmd_fall         = cmd_q & ~cmd_n;
    assign why.supply_drop  = vdd_low;
    assign why.card_gone    = ~card_in;
    assign why.host_end     = cmd_n;
    assign live             = state_live(state);
    assign abort_now        = live & cause_any(why);
    assign start_ok         = (state == SEQ_IDLE) & ready & ~vdd_low & card_in & cmd_fall;
    assign fault_evt        = live & cause_fault(why);

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:  if (start_ok) nxt = SEQ_START;
            SEQ_START: if (abort_now) nxt = SEQ_STOP;
                       else if (act_ack) nxt = SEQ_RUN;
            SEQ_RUN:   if (abort_now) nxt = SEQ_STOP;
            SEQ_STOP:  if (deact_ack) nxt = SEQ_IDLE;
            default:   nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            deact_req <= 1'b0;
        end else begin
            state     <= nxt;
            deact_req <= abort_now;
        end
    end

    assign act_req       = (state == SEQ_START);
    assign contacts_live = (state != SEQ_IDLE);

    // R2
    locked_ignores_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && !ready) |=> !contacts_live);

    // R5
    undervolt_deact_chk: assert property (@(posedge clk) disable iff (rst)
        (live && vdd_low) |=> (deact_req && contacts_live && !act_req));

    // R5
    deact_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        deact_req |=> !deact_req);

    // R6
    idle_no_deact_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE) |=> !deact_req);

    // R12
    low_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && vdd_low) |=> !act_req);

endmodule

// File: rtl/supv_status.sv
module supv_status (
    input  logic clk,
    input  logic rst,
    input  logic card_in,
    input  logic cmd_n,
    input  logic fault_evt,
    output logic status_off
);
    logic fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q    <= 1'b0;
            status_off <= 1'b0;
        end else begin
            if (fault_evt)  fault_q <= 1'b1;
            else if (cmd_n) fault_q <= 1'b0;
            status_off <= cmd_n ? card_in : ~fault_q;
        end
    end

    // R9
    presence_report_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_n |=> (status_off == $past(card_in)));

endmodule

// File: rtl/scard_supv_ctrl.sv
module scard_supv_ctrl #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic vdd_ok,
    input  logic vdd_low,
    input  logic card_in,
    input  logic cmd_n,
    input  logic act_ack,
    input  logic deact_ack,
    output logic if_enable,
    output logic act_req,
    output logic deact_req,
    output logic contacts_live,
    output logic status_off
);
    logic ready, fault_evt;

    supv_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .vdd_ok (vdd_ok),
        .vdd_low(vdd_low),
        .ready  (ready)
    );

    supv_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .ready        (ready),
        .vdd_low      (vdd_low),
        .card_in      (card_in),
        .cmd_n        (cmd_n),
        .act_ack      (act_ack),
        .deact_ack    (deact_ack),
        .act_req      (act_req),
        .deact_req    (deact_req),
        .contacts_live(contacts_live),
        .fault_evt    (fault_evt)
    );

    supv_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .card_in   (card_in),
        .cmd_n     (cmd_n),
        .fault_evt (fault_evt),
        .status_off(status_off)
    );

    assign if_enable = ready;

    // R11
    inactive_grounded_chk: assert property (@(posedge clk) disable iff (rst)
        act_req |-> contacts_live);

endmodule

// File: tb/scard_supv_ctrl_test.sv
module scard_supv_ctrl_test;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst, vdd_ok, vdd_low, card_in, cmd_n, act_ack, deact_ack;
    logic if_enable, act_req, deact_req, contacts_live, status_off;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scard_supv_ctrl #(.HOLD_CYC(H)) uut (
        .clk(clk), .rst(rst), .vdd_ok(vdd_ok), .vdd_low(vdd_low),
        .card_in(card_in), .cmd_n(cmd_n), .act_ack(act_ack),
        .deact_ack(deact_ack), .if_enable(if_enable), .act_req(act_req),
        .deact_req(deact_req), .contacts_live(contacts_live),
        .status_off(status_off)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic regain();
        vdd_low = 1'b0; vdd_ok = 1'b1;
        repeat (H) step();
        check("R2 regain if_enable", if_enable, 1'b1);
    endtask

    task automatic open_session();
        cmd_n = 1'b1; step();
        cmd_n = 1'b0; step();
        check("R4 act_req", act_req, 1'b1);
        check("R4 contacts_live", contacts_live, 1'b1);
        act_ack = 1'b1; step(); act_ack = 1'b0;
        check("R4 act_req cleared", act_req, 1'b0);
        check("R4 contacts stay live", contacts_live, 1'b1);
    endtask

    task automatic ack_deact();
        deact_ack = 1'b1; step(); deact_ack = 1'b0;
        check("R11 contacts grounded", contacts_live, 1'b0);
    endtask

    initial begin
        rst = 1'b1; vdd_ok = 1'b0; vdd_low = 1'b1; card_in = 1'b1;
        cmd_n = 1'b1; act_ack = 1'b0; deact_ack = 1'b0;
        step(); step();
        check("R1 if_enable", if_enable, 1'b0);
        check("R1 contacts_live", contacts_live, 1'b0);
        check("R1 act_req", act_req, 1'b0);
        check("R1 deact_req", deact_req, 1'b0);
        check("R1 status_off", status_off, 1'b0);
        rst = 1'b0;

        // R3 sweep: interrupt the hold-off at each point, with a command edge
        for (int k = 1; k < H; k++) begin
            vdd_low = 1'b0; vdd_ok = 1'b1; cmd_n = 1'b1;
            repeat (k) step();
            check("R3 not yet enabled", if_enable, 1'b0);
            cmd_n = 1'b0; step();
            check("R2 cmd ignored while locked", contacts_live, 1'b0);
            vdd_low = 1'b1; vdd_ok = 1'b0; cmd_n = 1'b1; step();
            check("R3 restart", if_enable, 1'b0);
        end

        // R2 exact hold-off length
        vdd_low = 1'b0; vdd_ok = 1'b1;
        repeat (H - 1) step();
        check("R2 one short", if_enable, 1'b0);
        step();
        check("R2 enabled", if_enable, 1'b1);

        // R9 presence sweep with cmd_n high
        for (int c = 0; c < 2; c++) begin
            card_in = c[0]; cmd_n = 1'b1; step();
            check("R9 status follows card", status_off, c[0]);
        end

        // R4 no card: no activation
        card_in = 1'b0; cmd_n = 1'b0; step();
        check("R4 no card no act", act_req, 1'b0);
        card_in = 1'b1; cmd_n = 1'b1; step();

        // R5 undervoltage during session
        open_session();
        step();
        check("R10 status high in clean session", status_off, 1'b1);
        vdd_low = 1'b1; step();
        check("R5 deact_req pulse", deact_req, 1'b1);
        check("R3 enable dropped", if_enable, 1'b0);
        step();
        check("R5 pulse one cycle", deact_req, 1'b0);
        check("R5 contacts held until ack", contacts_live, 1'b1);
        check("R10 fault status", status_off, 1'b0);
        ack_deact();
        cmd_n = 1'b1; step(); step();
        check("R9 status after session", status_off, 1'b1);
        regain();

        // R6 undervoltage while inactive
        vdd_low = 1'b1; step();
        check("R6 no deact_req", deact_req, 1'b0);
        step();
        check("R6 no deact_req later", deact_req, 1'b0);
        regain();

        // R7 card removal during session
        open_session();
        card_in = 1'b0; step();
        check("R7 deact_req", deact_req, 1'b1);
        step();
        check("R10 fault status card", status_off, 1'b0);
        ack_deact();
        card_in = 1'b1; cmd_n = 1'b1; step(); step();
        check("R9 status card back", status_off, 1'b1);

        // R8 host ends session
        open_session();
        cmd_n = 1'b1; step();
        check("R8 deact_req", deact_req, 1'b1);
        step();
        check("R8 status no fault", status_off, 1'b1);
        ack_deact();

        // R12 undervoltage with command edge
        cmd_n = 1'b0; vdd_low = 1'b1; step();
        check("R12 no act on coincident low", act_req, 1'b0);
        check("R12 contacts stay off", contacts_live, 1'b0);
        cmd_n = 1'b1;
        regain();

        // R12 undervoltage with act_ack
        cmd_n = 1'b0; step();
        check("R12 act_req", act_req, 1'b1);
        act_ack = 1'b1; vdd_low = 1'b1; step();
        act_ack = 1'b0;
        check("R12 deact wins", deact_req, 1'b1);
        check("R12 act_req cleared", act_req, 1'b0);
        step();
        check("R12 contacts until ack", contacts_live, 1'b1);
        ack_deact();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule